// File: doc/BRIEF.md
# Key Matrix Scan Controller

This block drives the row lines of a key matrix and reads the column returns. It has up to six scan outputs and five return inputs, so it can serve 30 keys. Return inputs are held low outside the block, so a return reads high only while a pressed key joins it to a scan line that is driven high. When no scan is running, the scan lines sit at a standby pattern chosen by a two-bit sleep code. The block starts a scan only when some return input reads high against that pattern.

A scan drives each usable line high by itself for a fixed number of oscillator ticks. At the last tick of each slot the return inputs are captured into that line's five bits of a key bitmap. After the last line the block raises a ready flag for the host and holds it until the host acknowledges the read. A two-bit key-select code can give the lowest one or two scan lines over to segment use. Those lines then stay low, are never scanned, and read as zero in the bitmap.

Top module: `keyscan_ctrl`

## Requirements
- R1: While no scan runs, each usable scan line shows its standby level from `sleep_code`. 2'b00 drives all lines high. 2'b01 drives all lines low. 2'b10 drives only the highest line (index 5) high. 2'b11 drives every line high except line 0.
- R2: `key_sel` 2'b00 keeps all six lines, 2'b01 removes line 0, and 2'b10 or 2'b11 removes lines 0 and 1. A removed line is driven low in every state, and its bitmap bits are zero after a scan.
- R3: A scan starts on a `tick` only when no scan is running, `data_ready` is low and at least one return input is high. If no pressed key meets a line that is high in standby, no scan starts and `data_ready` stays low.
- R4: During a scan exactly one line is high at a time. The lines are visited in rising order from the first usable line to line 5, each for `SLOT_TICKS` ticks. With a tick every third clock, `scan_busy` stays high for 3*SLOT_TICKS*(lines used) clocks.
- R5: At the last tick of line i's slot, return input r is captured into `key_data[i*5+r]`. The bitmap equals the pressed-key set restricted to the usable lines.
- R6: `data_ready` rises in the clock where a scan ends and stays high until `data_ack` is seen. It falls one clock after `data_ack`, and no new scan starts while it is high.
- R7: If `data_ack` is high in the same clock in which a scan ends, the completion wins and `data_ready` is set.
- R8: While `rst_n` is low, `key_data` and `data_ready` are cleared at once and no scan runs. Release takes effect after two clock edges.
- R9: `key_data` does not change while `data_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse per oscillator tick (scan time base) |
| sleep_code | input | 2 | Standby pattern select |
| key_sel | input | 2 | Number of low scan lines given to segment use |
| key_ret | input | 5 | Return inputs from the matrix, pulled low outside |
| data_ack | input | 1 | Host has read the bitmap; clears the ready flag |
| scan_out | output | 6 | Scan line drive, bit i is line i |
| key_data | output | 30 | Key bitmap, bit i*5+r is line i, return r |
| data_ready | output | 1 | A fresh bitmap is waiting |
| scan_busy | output | 1 | A scan is in progress |

## Verification
The end of a scan and a host acknowledge can land in the same clock. The first sets the ready flag and the second clears it, so the priority between them decides whether a bitmap is lost. The bench holds `data_ack` high for a whole scan with keys pressed, so the acknowledge overlaps the completing tick whenever that tick falls. It then counts how many sampled clocks show `data_ready` high. Exactly one clock is expected: the completion sets the flag and the still-asserted acknowledge clears it one clock later. A design that lets the acknowledge win would show zero.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // Number of low scan lines handed over to segment use.
  function automatic logic [1:0] lines_removed(input logic [1:0] ksel);
    logic [1:0] n;
    case (ksel)
      2'b00:   n = 2'd0;
      2'b01:   n = 2'd1;
      default: n = 2'd2;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/keyscan_rst_sync.sv
module keyscan_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/keyscan_seq.sv
module keyscan_seq
  import keyscan_pkg::*;
#(
  parameter int NUM_SCAN   = 6,
  parameter int NUM_RET    = 5,
  parameter int SLOT_TICKS = 4,
  localparam int LW = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1,
  localparam int SW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1,
  localparam int KW = NUM_SCAN * NUM_RET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    key_sel,
  input  logic [NUM_RET-1:0] key_ret,
  input  logic          data_ack,
  output logic          busy,
  output logic [LW-1:0] line_idx,
  output logic          ready,
  output logic [KW-1:0] bitmap
);

  localparam logic [LW-1:0] LAST_LINE = LW'(NUM_SCAN - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOT_TICKS - 1);

  scan_state_e   state_q, state_d;
  logic [LW-1:0] line_q, line_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [KW-1:0] map_q, map_d;
  logic          rdy_q, rdy_d;
  logic          scan_done;

  always_comb begin
    state_d   = state_q;
    line_d    = line_q;
    slot_d    = slot_q;
    map_d     = map_q;
    scan_done = 1'b0;
    if (tick) begin
      case (state_q)
        SCAN_IDLE: begin
          if (!rdy_q && (|key_ret)) begin
            state_d = SCAN_RUN;
            line_d  = LW'(lines_removed(key_sel));
            slot_d  = '0;
            map_d   = '0;
          end
        end
        default: begin
          if (slot_q == LAST_SLOT) begin
            map_d[int'(line_q)*NUM_RET +: NUM_RET] = key_ret;
            slot_d = '0;
            if (line_q == LAST_LINE) begin
              state_d   = SCAN_IDLE;
              scan_done = 1'b1;
            end else begin
              line_d = line_q + 1'b1;
            end
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end
      endcase
    end
    // completion has priority over the host acknowledge
    if (scan_done)     rdy_d = 1'b1;
    else if (data_ack) rdy_d = 1'b0;
    else               rdy_d = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      line_q  <= '0;
      slot_q  <= '0;
      map_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
      slot_q  <= slot_d;
      map_q   <= map_d;
      rdy_q   <= rdy_d;
    end
  end

  assign busy     = (state_q == SCAN_RUN);
  assign line_idx = line_q;
  assign ready    = rdy_q;
  assign bitmap   = map_q;

endmodule

// File: rtl/keyscan_drive.sv
module keyscan_drive
  import keyscan_pkg::*;
#(
  parameter int NUM_SCAN = 6,
  localparam int LW = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1
) (
  input  logic                busy,
  input  logic [LW-1:0]       line_idx,
  input  logic [1:0]          sleep_code,
  input  logic [1:0]          key_sel,
  output logic [NUM_SCAN-1:0] scan_out
);

  logic [NUM_SCAN-1:0] usable;
  logic [NUM_SCAN-1:0] standby;
  logic [NUM_SCAN-1:0] active;

  always_comb begin
    usable = {NUM_SCAN{1'b1}} << lines_removed(key_sel);
    case (sleep_code)
      2'b00:   standby = {NUM_SCAN{1'b1}};
      2'b01:   standby = '0;
      2'b10:   standby = NUM_SCAN'(1) << (NUM_SCAN - 1);
      default: standby = ~NUM_SCAN'(1);
    endcase
  end

  for (genvar g = 0; g < NUM_SCAN; g++) begin : g_line
    assign active[g] = busy ? (line_idx == LW'(g)) : standby[g];
  end

  assign scan_out = active & usable;

endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
#(
  parameter int NUM_SCAN   = 6,
  parameter int NUM_RET    = 5,
  parameter int SLOT_TICKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [1:0]                   sleep_code,
  input  logic [1:0]                   key_sel,
  input  logic [NUM_RET-1:0]           key_ret,
  input  logic                         data_ack,
  output logic [NUM_SCAN-1:0]          scan_out,
  output logic [NUM_SCAN*NUM_RET-1:0]  key_data,
  output logic                         data_ready,
  output logic                         scan_busy
);

  localparam int LW = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1;

  logic          rst_int_n;
  logic [LW-1:0] line_idx;

  keyscan_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  keyscan_seq #(
    .NUM_SCAN   (NUM_SCAN),
    .NUM_RET    (NUM_RET),
    .SLOT_TICKS (SLOT_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .key_sel  (key_sel),
    .key_ret  (key_ret),
    .data_ack (data_ack),
    .busy     (scan_busy),
    .line_idx (line_idx),
    .ready    (data_ready),
    .bitmap   (key_data)
  );

  keyscan_drive #(
    .NUM_SCAN (NUM_SCAN)
  ) u_drive (
    .busy       (scan_busy),
    .line_idx   (line_idx),
    .sleep_code (sleep_code),
    .key_sel    (key_sel),
    .scan_out   (scan_out)
  );

endmodule

// File: rtl/keyscan_ctrl_chk.sv
module keyscan_ctrl_chk #(
  parameter int NUM_SCAN = 6,
  parameter int NUM_RET  = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic [1:0]                  sleep_code,
  input logic [1:0]                  key_sel,
  input logic [NUM_RET-1:0]          key_ret,
  input logic                        data_ack,
  input logic [NUM_SCAN-1:0]         scan_out,
  input logic [NUM_SCAN*NUM_RET-1:0] key_data,
  input logic                        data_ready,
  input logic                        scan_busy
);

  logic [NUM_SCAN-1:0] kept;
  logic [NUM_SCAN-1:0] park;

  always_comb begin
    kept = '1;
    if (key_sel != 2'b00) kept[0] = 1'b0;
    if (key_sel[1])       kept[1] = 1'b0;
    park = '0;
    for (int i = 0; i < NUM_SCAN; i++) begin
      if (sleep_code == 2'b00) park[i] = 1'b1;
      if (sleep_code == 2'b10 && i == NUM_SCAN - 1) park[i] = 1'b1;
      if (sleep_code == 2'b11 && i != 0) park[i] = 1'b1;
    end
  end

  assert_standby_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_busy |-> scan_out == (park & kept));

  assert_removed_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_out & ~kept) == '0);

  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy) |-> $past(tick) && ($past(key_ret) != '0) && !$past(data_ready));

  assert_single_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> $onehot0(scan_out));

  assert_ready_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $fell(scan_busy));

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready && !data_ack |=> data_ready);

  assert_clear_in_reset_R8: assert property (@(posedge clk)
    !rst_n |-> (key_data == '0) && !data_ready && !scan_busy);

  assert_map_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> $stable(key_data));

endmodule

bind keyscan_ctrl keyscan_ctrl_chk #(
  .NUM_SCAN (NUM_SCAN),
  .NUM_RET  (NUM_RET)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .sleep_code (sleep_code),
  .key_sel    (key_sel),
  .key_ret    (key_ret),
  .data_ack   (data_ack),
  .scan_out   (scan_out),
  .key_data   (key_data),
  .data_ready (data_ready),
  .scan_busy  (scan_busy)
);

// File: tb/keyscan_ctrl_tb_top.sv
module keyscan_ctrl_tb_top;

  localparam int NS   = 6;
  localparam int NR   = 5;
  localparam int SLOT = 4;
  localparam int KW   = NS * NR;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic [1:0]    sleep_code;
  logic [1:0]    key_sel;
  logic [NR-1:0] key_ret;
  logic          data_ack;
  logic [NS-1:0] scan_out;
  logic [KW-1:0] key_data;
  logic          data_ready;
  logic          scan_busy;
  logic [KW-1:0] pressed;

  int checks;
  int failures;
  int cyc;
  int tdiv;

  keyscan_ctrl #(.NUM_SCAN(NS), .NUM_RET(NR), .SLOT_TICKS(SLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_code(sleep_code),
    .key_sel(key_sel), .key_ret(key_ret), .data_ack(data_ack),
    .scan_out(scan_out), .key_data(key_data), .data_ready(data_ready),
    .scan_busy(scan_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // matrix model: a return is high when a pressed key meets a high line
  always_comb begin
    key_ret = '0;
    for (int i = 0; i < NS; i++)
      if (scan_out[i]) key_ret = key_ret | pressed[i*NR +: NR];
  end

  // one tick every third clock
  always @(negedge clk) begin
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 1);
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<=190000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int first_of(input logic [1:0] ks);
    return (ks == 2'b00) ? 0 : ((ks == 2'b01) ? 1 : 2);
  endfunction

  function automatic logic [NS-1:0] park_of(input logic [1:0] sc);
    case (sc)
      2'b00:   return '1;
      2'b01:   return '0;
      2'b10:   return NS'(1) << (NS - 1);
      default: return ~NS'(1);
    endcase
  endfunction

  task automatic settle_idle();
    pressed = '0;
    for (int n = 0; n < 200 && scan_busy; n++) @(negedge clk);
    data_ack = 1'b1;
    @(negedge clk);
    data_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic trial(input logic [1:0] sc, input logic [1:0] ks,
                       input logic [KW-1:0] pat);
    int            fl;
    logic [NS-1:0] use_m;
    logic [NS-1:0] pk;
    logic [KW-1:0] exp;
    bit            det;
    bit            seen;
    int            busy_cyc;
    logic [KW-1:0] snap;
    fl = first_of(ks);
    use_m = '1 << fl;
    pk = park_of(sc);
    sleep_code = sc;
    key_sel = ks;
    @(negedge clk);
    chk(scan_out == (pk & use_m), "R1/R2 standby", 64'(scan_out), 64'(pk & use_m));
    exp = '0;
    det = 1'b0;
    for (int i = fl; i < NS; i++) begin
      exp[i*NR +: NR] = pat[i*NR +: NR];
      if (pk[i] && (pat[i*NR +: NR] != '0)) det = 1'b1;
    end
    pressed = pat;
    seen = 1'b0;
    busy_cyc = 0;
    for (int n = 0; n < 100 && !seen; n++) begin
      @(negedge clk);
      if (scan_busy) busy_cyc++;
      if (data_ready) seen = 1'b1;
    end
    chk(seen == det, "R3 scan start", 64'(seen), 64'(det));
    if (det && seen) begin
      chk(key_data == exp, "R5/R2 bitmap", 64'(key_data), 64'(exp));
      chk(busy_cyc == 3 * SLOT * (NS - fl), "R4 scan length", 64'(busy_cyc),
          64'(3 * SLOT * (NS - fl)));
      snap = key_data;
      repeat (12) @(negedge clk);
      chk(data_ready && !scan_busy, "R6 ready held, no rescan",
          64'({data_ready, scan_busy}), 64'(2'b10));
      chk(key_data == snap, "R9 bitmap stable", 64'(key_data), 64'(snap));
      pressed = '0;
      data_ack = 1'b1;
      @(negedge clk);
      data_ack = 1'b0;
      chk(!data_ready, "R6 ack clears", 64'(data_ready), 64'(0));
    end
    settle_idle();
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0; tdiv = 0; tick = 1'b0;
    rst_n = 1'b0; sleep_code = 2'b00; key_sel = 2'b00;
    data_ack = 1'b0; pressed = '0;
    repeat (4) @(negedge clk);
    chk(key_data == '0 && !data_ready && !scan_busy, "R8 reset state",
        64'({key_data, data_ready, scan_busy}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        for (int b = 0; b < KW; b++) trial(2'(s), 2'(k), KW'(1) << b);
        trial(2'(s), 2'(k), '1);
        trial(2'(s), 2'(k), 30'h2AAA_AAAA);
      end

    // R7: acknowledge held across the completing clock
    sleep_code = 2'b00; key_sel = 2'b00;
    data_ack = 1'b1;
    pressed = '1;
    begin
      int hi;
      int n;
      hi = 0;
      n = 0;
      while (!data_ready && n < 120) begin @(negedge clk); n++; end
      for (int m = 0; m < 20; m++) begin
        if (data_ready) hi++;
        @(negedge clk);
      end
      chk(hi == 1, "R7 completion beats ack", 64'(hi), 64'(1));
    end
    data_ack = 1'b0;
    settle_idle();

    // R8: reset mid-life clears data and blocks scanning
    pressed = '1;
    for (int n = 0; n < 120 && !data_ready; n++) @(negedge clk);
    chk(data_ready && key_data == '1, "R8 precondition full map",
        64'(key_data), 64'({KW{1'b1}}));
    #1 rst_n = 1'b0;
    #1;
    chk(key_data == '0 && !data_ready, "R8 async clear",
        64'({key_data, data_ready}), 64'(0));
    begin
      bit ran;
      ran = 1'b0;
      repeat (10) begin @(negedge clk); if (scan_busy) ran = 1'b1; end
      chk(!ran, "R8 no scan in reset", 64'(ran), 64'(0));
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scan_busy, "R8 release sync", 64'(scan_busy), 64'(0));
    for (int n = 0; n < 120 && !data_ready; n++) @(negedge clk);
    chk(data_ready && key_data == '1, "R8 scan resumes", 64'(key_data),
        64'({KW{1'b1}}));
    settle_idle();

    report();
  end

endmodule